// File: doc/BRIEF.md
# Bit-Manipulation Decode and Execute Unit

This unit recognises the basic bit-manipulation instructions of a RISC-V integer core and computes their results. Each cycle it takes a 32-bit instruction word, two XLEN-bit source operands, an enable for the bit-manipulation extension and a flag that says the hart runs in 64-bit mode. One clock edge later it presents a legality flag and the result.

The supported operations are:
- the inverted logic forms andn, orn and xnor;
- signed and unsigned minimum and maximum;
- left and right rotates, by register and by immediate;
- leading-zero count, trailing-zero count and population count;
- sign extension from a byte and from a halfword;
- the 32-bit word variants that a 64-bit core needs.

An execute stage places the unit beside its main ALU. It uses the legality flag to choose between this unit's result and an illegal-instruction trap.

Top module: `bitmanip_unit`

## Requirements
- R1: When `ext_en` is low, every encoding gives `legal_q` = 0 and `result_q` = 0.
- R2: The word forms are legal only when `mode64` is high and XLEN is 64. The word forms are the encodings with opcode 0011011 or 0111011. In any other case they give `legal_q` = 0 and `result_q` = 0.
- R3: An encoding that matches no pattern listed here gives `legal_q` = 0 and `result_q` = 0. Examples are an opcode outside the four listed, an unused funct3 and an unused unary selector.
- R4: Opcode 0110011 with funct7 0100000 selects three operations by funct3:
  - 111 gives a & ~b;
  - 110 gives a | ~b;
  - 100 gives ~(a ^ b).
- R5: Opcode 0110011 with funct7 0000101 selects four operations by funct3:
  - 100 is the signed minimum;
  - 101 is the unsigned minimum;
  - 110 is the signed maximum;
  - 111 is the unsigned maximum.
- R6: Opcode 0110011 with funct7 0110000 is a rotate. funct3 001 rotates left and funct3 101 rotates right. The amount is the low log2(XLEN) bits of b.
  The immediate right rotate has opcode 0010011, funct3 101 and bits [31:26] = 011000. Its amount is in bits [25:20]. Bit 25 set makes it illegal unless the core runs in 64-bit mode.
- R7: Opcode 0010011 with funct3 001 and bits [31:25] = 0110000 is a unary operation, selected by bits [24:20]:
  - 00000 counts leading zeros;
  - 00001 counts trailing zeros;
  - 00010 counts set bits.
  Both zero counts return XLEN for a zero operand. All three counts are zero-extended.
- R8: The same unary group with bits [24:20] = 00100 copies bit 7 into all higher result bits. With bits [24:20] = 00101 it copies bit 15 into all higher result bits.
- R9: Opcode 0011011 with bits [31:25] = 0110000 and funct3 001 is a word count, selected by bits [24:20] = 00000, 00001 or 00010. The word counts work on a[31:0] only. The leading and trailing counts return 32 for a zero low word.
- R10: The word rotates rotate a[31:0] by a 5-bit amount and sign-extend the 32-bit result to 64 bits.
  - Opcode 0111011 with funct7 0110000 rotates left with funct3 001 and right with funct3 101. The amount is b[4:0].
  - Opcode 0011011 with funct7 0110000 and funct3 101 rotates right. The amount is bits [24:20].
- R11: `legal_q` and `result_q` are registered and appear one clock after the inputs. A synchronous high `rst` clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Bit-manipulation extension enabled |
| mode64 | input | 1 | Hart runs in 64-bit mode |
| insn | input | 32 | Instruction word |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| legal_q | output | 1 | Registered: instruction is a legal member of the group |
| result_q | output | XLEN | Registered result, zero when not legal |

## Verification
The properties assume that `insn`, `ext_en` and `mode64` hold known values whenever reset is low. They also assume that the unit evaluates an instruction every cycle, with no valid qualifier. The stimulus changes all inputs only on falling edges and leaves every field known. The stimulus builds encodings from the listed patterns and adds a handful of deliberately unmatched words. Operands are either edge values or fully random words from a fixed seed, so no bit is ever X.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMM32 = 7'b0011011;
  localparam logic [6:0] OPC_REG32 = 7'b0111011;

  typedef enum logic [4:0] {
    BOP_NONE,
    BOP_ANDN, BOP_ORN, BOP_XNOR,
    BOP_MIN, BOP_MINU, BOP_MAX, BOP_MAXU,
    BOP_ROL, BOP_ROR, BOP_RORI,
    BOP_CLZ, BOP_CTZ, BOP_CPOP,
    BOP_SEXTB, BOP_SEXTH,
    BOP_CLZW, BOP_CTZW, BOP_CPOPW,
    BOP_ROLW, BOP_RORW, BOP_RORIW
  } bop_e;

  function automatic logic is_word_op(bop_e op);
    return (op == BOP_CLZW) || (op == BOP_CTZW) || (op == BOP_CPOPW) ||
           (op == BOP_ROLW) || (op == BOP_RORW) || (op == BOP_RORIW);
  endfunction

endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] lead,
  output logic [CW-1:0] trail,
  output logic [CW-1:0] ones
);

  // Leading count: the highest set bit wins because it is visited last.
  always_comb begin
    lead = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) lead = CW'(W - 1 - i);
    end
  end

  // Trailing count: the lowest set bit wins because it is visited last.
  always_comb begin
    trail = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) trail = CW'(i);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [6:0]     f7,
  input  logic [4:0]     sel5,
  input  logic [2:0]     f3,
  input  logic [6:0]     opc,
  input  logic           ext_en,
  input  logic           mode64,
  output bop_e           op,
  output logic [SHW-1:0] imm_sh,
  output logic           legal
);

  localparam bit HAS_WORD = (XLEN == 64);

  logic wide_ok;
  assign wide_ok = HAS_WORD && mode64;

  always_comb begin
    op = BOP_NONE;
    case (opc)
      OPC_REG: begin
        case (f7)
          7'b0100000: begin
            case (f3)
              3'b111:  op = BOP_ANDN;
              3'b110:  op = BOP_ORN;
              3'b100:  op = BOP_XNOR;
              default: op = BOP_NONE;
            endcase
          end
          7'b0000101: begin
            case (f3)
              3'b100:  op = BOP_MIN;
              3'b101:  op = BOP_MINU;
              3'b110:  op = BOP_MAX;
              3'b111:  op = BOP_MAXU;
              default: op = BOP_NONE;
            endcase
          end
          7'b0110000: begin
            if (f3 == 3'b001)      op = BOP_ROL;
            else if (f3 == 3'b101) op = BOP_ROR;
          end
          default: op = BOP_NONE;
        endcase
      end
      OPC_IMM: begin
        if (f3 == 3'b001 && f7 == 7'b0110000) begin
          case (sel5)
            5'b00000: op = BOP_CLZ;
            5'b00001: op = BOP_CTZ;
            5'b00010: op = BOP_CPOP;
            5'b00100: op = BOP_SEXTB;
            5'b00101: op = BOP_SEXTH;
            default:  op = BOP_NONE;
          endcase
        end else if (f3 == 3'b101 && f7[6:1] == 6'b011000) begin
          if (!f7[0] || wide_ok) op = BOP_RORI;
        end
      end
      OPC_IMM32: begin
        if (f7 == 7'b0110000) begin
          if (f3 == 3'b001) begin
            case (sel5)
              5'b00000: op = BOP_CLZW;
              5'b00001: op = BOP_CTZW;
              5'b00010: op = BOP_CPOPW;
              default:  op = BOP_NONE;
            endcase
          end else if (f3 == 3'b101) begin
            op = BOP_RORIW;
          end
        end
      end
      OPC_REG32: begin
        if (f7 == 7'b0110000) begin
          if (f3 == 3'b001)      op = BOP_ROLW;
          else if (f3 == 3'b101) op = BOP_RORW;
        end
      end
      default: op = BOP_NONE;
    endcase
  end

  generate
    if (SHW > 5) begin : g_sh_wide
      assign imm_sh = SHW'({f7[0], sel5});
    end else begin : g_sh_narrow
      assign imm_sh = sel5[SHW-1:0];
    end
  endgenerate

  assign legal = ext_en && (op != BOP_NONE) && (!is_word_op(op) || wide_ok);

endmodule

// File: rtl/bmu_exec.sv
module bmu_exec
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  bop_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SHW-1:0]  imm_sh,
  output logic [XLEN-1:0] res
);

  localparam int CW  = SHW + 1;
  localparam int WCW = 6;

  logic [CW-1:0]   lz, tz, pc;
  logic [SHW-1:0]  amt;
  logic [2*XLEN-1:0] dbl_l, dbl_r;
  logic [XLEN-1:0] rot_l, rot_r;
  logic [XLEN-1:0] word_res;

  bmu_count #(.W(XLEN), .CW(CW)) u_cnt_full (
    .vec  (a),
    .lead (lz),
    .trail(tz),
    .ones (pc)
  );

  assign amt   = (op == BOP_RORI) ? imm_sh : b[SHW-1:0];
  assign dbl_l = {a, a} << amt;
  assign dbl_r = {a, a} >> amt;
  assign rot_l = dbl_l[2*XLEN-1:XLEN];
  assign rot_r = dbl_r[XLEN-1:0];

  generate
    if (XLEN > 32) begin : g_word
      logic [WCW-1:0] wlz, wtz, wpc;
      logic [4:0]     wamt;
      logic [63:0]    wdl, wdr;
      logic [31:0]    wrot;

      bmu_count #(.W(32), .CW(WCW)) u_cnt_word (
        .vec  (a[31:0]),
        .lead (wlz),
        .trail(wtz),
        .ones (wpc)
      );

      assign wamt = (op == BOP_RORIW) ? imm_sh[4:0] : b[4:0];
      assign wdl  = {a[31:0], a[31:0]} << wamt;
      assign wdr  = {a[31:0], a[31:0]} >> wamt;
      assign wrot = (op == BOP_ROLW) ? wdl[63:32] : wdr[31:0];

      always_comb begin
        case (op)
          BOP_CLZW:  word_res = XLEN'(wlz);
          BOP_CTZW:  word_res = XLEN'(wtz);
          BOP_CPOPW: word_res = XLEN'(wpc);
          default:   word_res = {{(XLEN-32){wrot[31]}}, wrot};
        endcase
      end
    end else begin : g_no_word
      assign word_res = '0;
    end
  endgenerate

  always_comb begin
    case (op)
      BOP_ANDN:  res = a & ~b;
      BOP_ORN:   res = a | ~b;
      BOP_XNOR:  res = ~(a ^ b);
      BOP_MIN:   res = ($signed(a) < $signed(b)) ? a : b;
      BOP_MAX:   res = ($signed(a) < $signed(b)) ? b : a;
      BOP_MINU:  res = (a < b) ? a : b;
      BOP_MAXU:  res = (a < b) ? b : a;
      BOP_ROL:   res = rot_l;
      BOP_ROR,
      BOP_RORI:  res = rot_r;
      BOP_CLZ:   res = XLEN'(lz);
      BOP_CTZ:   res = XLEN'(tz);
      BOP_CPOP:  res = XLEN'(pc);
      BOP_SEXTB: res = {{(XLEN-8){a[7]}}, a[7:0]};
      BOP_SEXTH: res = {{(XLEN-16){a[15]}}, a[15:0]};
      BOP_CLZW, BOP_CTZW, BOP_CPOPW,
      BOP_ROLW, BOP_RORW, BOP_RORIW: res = word_res;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_en,
  input  logic            mode64,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            legal_q,
  output logic [XLEN-1:0] result_q
);

  localparam int SHW = $clog2(XLEN);

  bop_e            op;
  logic [SHW-1:0]  imm_sh;
  logic            legal;
  logic [XLEN-1:0] res;
  logic            unused_fields;

  assign unused_fields = ^{insn[19:15], insn[11:7]};

  bmu_decode #(.XLEN(XLEN), .SHW(SHW)) u_dec (
    .f7    (insn[31:25]),
    .sel5  (insn[24:20]),
    .f3    (insn[14:12]),
    .opc   (insn[6:0]),
    .ext_en(ext_en),
    .mode64(mode64),
    .op    (op),
    .imm_sh(imm_sh),
    .legal (legal)
  );

  bmu_exec #(.XLEN(XLEN), .SHW(SHW)) u_exe (
    .op    (op),
    .a     (src_a),
    .b     (src_b),
    .imm_sh(imm_sh),
    .res   (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      legal_q  <= 1'b0;
      result_q <= '0;
    end else begin
      legal_q  <= legal;
      result_q <= legal ? res : '0;
    end
  end

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_en,
  input logic            mode64,
  input logic [31:0]     insn,
  input logic            legal_q,
  input logic [XLEN-1:0] result_q
);

  logic opc_known, is_sextb, is_count;

  assign opc_known = (insn[6:0] == 7'b0110011) || (insn[6:0] == 7'b0010011) ||
                     (insn[6:0] == 7'b0011011) || (insn[6:0] == 7'b0111011);
  assign is_sextb  = (insn[31:20] == 12'b011000000100) && (insn[14:12] == 3'b001) &&
                     (insn[6:0] == 7'b0010011);
  assign is_count  = (insn[31:22] == 10'b0110000000) && (insn[21:20] != 2'b11) &&
                     (insn[14:12] == 3'b001) && (insn[6:0] == 7'b0010011);

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (!legal_q && result_q == '0));

  p_disabled_r1: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (!legal_q && result_q == '0));

  p_word_needs_64_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode64 && (insn[6:0] == 7'b0011011 || insn[6:0] == 7'b0111011)) |=> !legal_q);

  p_unknown_opc_r3: assert property (@(posedge clk) disable iff (rst)
    !opc_known |=> (!legal_q && result_q == '0));

  p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_en && is_count) |=> (legal_q && result_q <= XLEN'(XLEN)));

  p_sextb_uniform_r8: assert property (@(posedge clk) disable iff (rst)
    (ext_en && is_sextb) |=> (legal_q && (result_q[XLEN-1:7] == '0 || result_q[XLEN-1:7] == '1)));

endmodule

bind bitmanip_unit bmu_chk #(.XLEN(XLEN)) u_bmu_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_en  (ext_en),
  .mode64  (mode64),
  .insn    (insn),
  .legal_q (legal_q),
  .result_q(result_q)
);

// File: tb/test_bitmanip_unit.sv
`timescale 1ns/1ps
module test_bitmanip_unit;

  localparam int XLEN = 64;
  localparam int NOPS = 21;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ext_en = 1'b0;
  logic            mode64 = 1'b0;
  logic [31:0]     insn = '0;
  logic [XLEN-1:0] src_a = '0;
  logic [XLEN-1:0] src_b = '0;
  logic            legal_q;
  logic [XLEN-1:0] result_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitmanip_unit #(.XLEN(XLEN)) i_bitmanip_unit (
    .clk(clk), .rst(rst), .ext_en(ext_en), .mode64(mode64), .insn(insn),
    .src_a(src_a), .src_b(src_b), .legal_q(legal_q), .result_q(result_q)
  );

  // Operation indices used only by the bench
  // 0 andn 1 orn 2 xnor 3 min 4 minu 5 max 6 maxu 7 rol 8 ror 9 rori
  // 10 clz 11 ctz 12 cpop 13 sextb 14 sexth 15 clzw 16 ctzw 17 cpopw
  // 18 rolw 19 rorw 20 roriw
  function automatic logic [31:0] enc(int op, logic [5:0] sh);
    logic [31:0] r;
    case (op)
      0:  r = {7'b0100000, 5'd2, 5'd1, 3'b111, 5'd3, 7'b0110011};
      1:  r = {7'b0100000, 5'd2, 5'd1, 3'b110, 5'd3, 7'b0110011};
      2:  r = {7'b0100000, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011};
      3:  r = {7'b0000101, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011};
      4:  r = {7'b0000101, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0110011};
      5:  r = {7'b0000101, 5'd2, 5'd1, 3'b110, 5'd3, 7'b0110011};
      6:  r = {7'b0000101, 5'd2, 5'd1, 3'b111, 5'd3, 7'b0110011};
      7:  r = {7'b0110000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0110011};
      8:  r = {7'b0110000, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0110011};
      9:  r = {6'b011000, sh, 5'd1, 3'b101, 5'd3, 7'b0010011};
      10: r = {7'b0110000, 5'b00000, 5'd1, 3'b001, 5'd3, 7'b0010011};
      11: r = {7'b0110000, 5'b00001, 5'd1, 3'b001, 5'd3, 7'b0010011};
      12: r = {7'b0110000, 5'b00010, 5'd1, 3'b001, 5'd3, 7'b0010011};
      13: r = {7'b0110000, 5'b00100, 5'd1, 3'b001, 5'd3, 7'b0010011};
      14: r = {7'b0110000, 5'b00101, 5'd1, 3'b001, 5'd3, 7'b0010011};
      15: r = {7'b0110000, 5'b00000, 5'd1, 3'b001, 5'd3, 7'b0011011};
      16: r = {7'b0110000, 5'b00001, 5'd1, 3'b001, 5'd3, 7'b0011011};
      17: r = {7'b0110000, 5'b00010, 5'd1, 3'b001, 5'd3, 7'b0011011};
      18: r = {7'b0110000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0111011};
      19: r = {7'b0110000, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0111011};
      default: r = {7'b0110000, sh[4:0], 5'd1, 3'b101, 5'd3, 7'b0011011};
    endcase
    return r;
  endfunction

  function automatic string tag(int op);
    if (op <= 2)  return "R4";
    if (op <= 6)  return "R5";
    if (op <= 9)  return "R6";
    if (op <= 12) return "R7";
    if (op <= 14) return "R8";
    if (op <= 17) return "R9";
    return "R10";
  endfunction

  function automatic logic [63:0] rotl64(logic [63:0] v, int n);
    logic [63:0] r = v;
    for (int k = 0; k < n; k++) r = {r[62:0], r[63]};
    return r;
  endfunction

  function automatic logic [31:0] rotl32(logic [31:0] v, int n);
    logic [31:0] r = v;
    for (int k = 0; k < n; k++) r = {r[30:0], r[31]};
    return r;
  endfunction

  function automatic int lead_zeros(logic [63:0] v, int w);
    int n = 0;
    int i = w - 1;
    while (i >= 0 && !v[i]) begin n++; i--; end
    return n;
  endfunction

  function automatic int trail_zeros(logic [63:0] v, int w);
    int n = 0;
    while (n < w && !v[n]) n++;
    return n;
  endfunction

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b, logic [5:0] sh);
    case (op)
      0:  return a & ~b;
      1:  return a | ~b;
      2:  return ~(a ^ b);
      3:  return ($signed(a) <= $signed(b)) ? a : b;
      4:  return (a <= b) ? a : b;
      5:  return ($signed(a) >= $signed(b)) ? a : b;
      6:  return (a >= b) ? a : b;
      7:  return rotl64(a, int'(b[5:0]));
      8:  return rotl64(a, (64 - int'(b[5:0])) % 64);
      9:  return rotl64(a, (64 - int'(sh)) % 64);
      10: return 64'(lead_zeros(a, 64));
      11: return 64'(trail_zeros(a, 64));
      12: return 64'($countones(a));
      13: return {{56{a[7]}}, a[7:0]};
      14: return {{48{a[15]}}, a[15:0]};
      15: return 64'(lead_zeros({32'd0, a[31:0]}, 32));
      16: return 64'(trail_zeros({32'd0, a[31:0]}, 32));
      17: return 64'($countones(a[31:0]));
      18: return sx32(rotl32(a[31:0], int'(b[4:0])));
      19: return sx32(rotl32(a[31:0], (32 - int'(b[4:0])) % 32));
      default: return sx32(rotl32(a[31:0], (32 - int'(sh[4:0])) % 32));
    endcase
  endfunction

  task automatic compare(string t, logic exp_l, logic [63:0] exp_r);
    checks++;
    if (legal_q !== exp_l || result_q !== exp_r) begin
      failures++;
      $display("FAIL %s: legal=%0b result=%h expected legal=%0b result=%h",
               t, legal_q, result_q, exp_l, exp_r);
    end
  endtask

  task automatic drive(logic [31:0] w, logic [63:0] a, logic [63:0] b, logic en, logic m64);
    @(negedge clk);
    insn = w; src_a = a; src_b = b; ext_en = en; mode64 = m64;
    @(negedge clk);
  endtask

  task automatic run_op(int op, logic [63:0] a, logic [63:0] b, logic [5:0] sh,
                        logic en, logic m64, string t);
    logic lg;
    lg = en && (op < 15 || m64) && !(op == 9 && sh[5] && !m64);
    drive(enc(op, sh), a, b, en, m64);
    compare(t, lg, lg ? model(op, a, b, sh) : 64'd0);
  endtask

  task automatic run_bad(logic [31:0] w, string t);
    drive(w, 64'hDEAD_BEEF_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b1);
    compare(t, 1'b0, 64'd0);
  endtask

  function automatic logic [63:0] pick(int unsigned r);
    case (r % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'd1 << (r % 64);
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    compare("R11", 1'b0, 64'd0);
    rst = 1'b0;

    // Zero counts, all-ones count, edge positions
    run_op(10, 64'd0, 64'd0, 6'd0, 1, 1, "R7");
    run_op(11, 64'd0, 64'd0, 6'd0, 1, 1, "R7");
    run_op(12, '1, 64'd0, 6'd0, 1, 1, "R7");
    run_op(11, 64'h8000_0000_0000_0000, 64'd0, 6'd0, 1, 1, "R7");
    run_op(15, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0, 1, 1, "R9");
    run_op(16, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0, 1, 1, "R9");
    run_op(3, 64'h8000_0000_0000_0000, 64'd1, 6'd0, 1, 1, "R5");
    run_op(4, 64'h8000_0000_0000_0000, 64'd1, 6'd0, 1, 1, "R5");
    run_op(13, 64'h0000_0000_0000_0080, 64'd0, 6'd0, 1, 1, "R8");
    run_op(14, 64'h0000_0000_0000_7FFF, 64'd0, 6'd0, 1, 1, "R8");
    run_op(7, 64'h8000_0000_0000_0001, 64'd65, 6'd0, 1, 1, "R6");
    run_op(9, 64'h0000_0000_0000_0001, 64'd0, 6'd33, 1, 1, "R6");
    run_op(19, 64'h0000_0000_0000_0001, 64'd1, 6'd0, 1, 1, "R10");
    run_op(20, 64'h1234_5678_0000_0001, 64'd0, 6'd1, 1, 1, "R10");

    // R1: extension disabled
    run_op(12, '1, 64'd0, 6'd0, 0, 1, "R1");
    run_op(0, '1, 64'd0, 6'd0, 0, 1, "R1");
    // R2: word forms outside 64-bit mode
    run_op(15, 64'd5, 64'd0, 6'd0, 1, 0, "R2");
    run_op(18, 64'd5, 64'd3, 6'd0, 1, 0, "R2");
    // R6: immediate rotate bit 25 outside 64-bit mode, and without it
    run_op(9, 64'hF0, 64'd0, 6'd33, 1, 0, "R6");
    run_op(9, 64'hF0, 64'd0, 6'd3, 1, 0, "R6");
    // R3: unmatched encodings
    run_bad({7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, "R3");
    run_bad({7'b0110000, 5'b00011, 5'd1, 3'b001, 5'd3, 7'b0010011}, "R3");
    run_bad({7'b0110000, 5'b00100, 5'd1, 3'b001, 5'd3, 7'b0011011}, "R3");
    run_bad({7'b0110000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1111111}, "R3");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op  = $urandom % NOPS;
      logic [63:0] a   = pick($urandom);
      logic [63:0] b   = pick($urandom);
      logic [5:0]  sh  = 6'($urandom);
      logic        m64 = ($urandom % 4) != 0;
      logic        en  = ($urandom % 10) != 0;
      run_op(int'(op), a, b, sh, en, m64, en ? tag(int'(op)) : "R1");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self();
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule